// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block carries out the bus traffic of entering an interrupt handler once the core has decided to take an interrupt. A one-cycle take request latches the interrupt level, the current status word, the supervisor stack pointer and the return address. The sequencer then runs a fixed schedule of idle gaps and bus cycles. It stacks the old status word. It runs an interrupt-acknowledge cycle in CPU space to get a vector number. It stacks the return address, reads the handler address from the vector table, and issues two program fetches at the handler.

Every bus cycle ends on a termination input, so a slow slave stretches the schedule. During the acknowledge cycle three answers are possible: a data answer supplies the vector, a peripheral-valid answer selects an autovector, and a bus error selects the spurious vector. A peripheral-valid answer ends the acknowledge only when a separate synchronisation input, driven by an external slow-bus timing generator, is high. When the schedule finishes, the block presents the new status word, the new stack pointer and the handler address, and pulses a completion flag.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset, `busy`, `bus_as` and `done` are low.
- R2: A take request while idle starts the schedule. The schedule is: 6 idle clocks, status write, acknowledge, 4 idle clocks, return-address low-word write, return-address high-word write, vector high-word read, vector low-word read, fetch, 2 idle clocks, fetch. Each bus cycle lasts 4 clocks, so with immediate answers `busy` stays high for exactly 44 clocks, across 5 reads and 3 writes.
- R3: A bus cycle samples its termination in its third clock while `bus_as` is high. Each clock in which termination is absent adds one clock to the schedule.
- R4: The old status word is written to SP-6, return address bits 15:0 to SP-2, and return address bits 23:16 (zero-extended) to SP-4. All writes use function code 3'b101. `sv_sp` equals SP-6.
- R5: The acknowledge cycle is a read with function code 3'b111. Its address has bits 23:4 all ones, bits 3:1 equal to the level, and bit 0 zero.
- R6: If the acknowledge ends on `bus_dtack` alone, the vector number is `bus_rdata[7:0]`.
- R7: If `bus_vpa` is present, the acknowledge ends only in a clock where `bus_vpa_sync` is also high. The bus data is ignored and the vector number is 24 plus the level.
- R8: If `bus_berr` answers the acknowledge, the vector number is 24. This holds even when `bus_dtack` or `bus_vpa` is also high in that clock.
- R9: The vector table is read as a high word at vector×4 and a low word at vector×4+2, both with function code 3'b101. The handler address is {high[7:0], low}. Fetches read the handler address and the handler address +2, with function code 3'b110.
- R10: `sv_sr` equals the old status word with bit 15 cleared, bit 13 set, and bits 10:8 set to the level.
- R11: `done` is high for exactly the one clock after `busy` falls. Take requests while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Start interrupt entry (sampled only when idle) |
| irq_level | input | 3 | Level being serviced |
| cur_sr | input | 16 | Status word before entry |
| cur_sp | input | 24 | Supervisor stack pointer before entry |
| cur_pc | input | 24 | Return address |
| bus_addr | output | 24 | Bus address |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as | output | 1 | Address strobe |
| bus_fc | output | 3 | Function code |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_dtack | input | 1 | Data transfer acknowledge |
| bus_vpa | input | 1 | Peripheral-valid answer (autovector) |
| bus_vpa_sync | input | 1 | Slow-bus timing window for a peripheral-valid answer |
| bus_berr | input | 1 | Bus error |
| busy | output | 1 | Schedule running |
| done | output | 1 | One-clock completion pulse |
| sv_sr | output | 16 | New status word |
| sv_sp | output | 24 | New stack pointer |
| sv_pc | output | 24 | Handler address |

## Verification
Two answers can arrive in the same clock during the acknowledge cycle. A bus error can come together with a data acknowledge. A peripheral-valid answer can be present in clocks where the synchronisation window is closed. The bench provokes both cases with a responder that raises several termination inputs at once and a free-running window counter. It judges the outcome from the handler address fetched afterwards and from the schedule length, which must grow by exactly the number of clocks the responder left unterminated. A take request raised in the middle of a busy schedule is also checked: the stacked data and final results must stay unchanged.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_GAP_A,
        PH_PUSH_SR,
        PH_IACK,
        PH_GAP_B,
        PH_PUSH_PCL,
        PH_PUSH_PCH,
        PH_VEC_HI,
        PH_VEC_LO,
        PH_FETCH_A,
        PH_GAP_C,
        PH_FETCH_B
    } phase_e;

    localparam logic [2:0] FC_SDATA = 3'b101;
    localparam logic [2:0] FC_SPROG = 3'b110;
    localparam logic [2:0] FC_CPU   = 3'b111;
    localparam logic [7:0] VEC_SPURIOUS  = 8'd24;
    localparam logic [7:0] VEC_AUTO_BASE = 8'd24;

    function automatic logic is_bus(input phase_e ph);
        return !(ph inside {PH_IDLE, PH_GAP_A, PH_GAP_B, PH_GAP_C});
    endfunction

    function automatic logic [2:0] phase_len(input phase_e ph);
        case (ph)
            PH_GAP_A: return 3'd6;
            PH_GAP_B: return 3'd4;
            PH_GAP_C: return 3'd2;
            PH_IDLE:  return 3'd1;
            default:  return 3'd4;
        endcase
    endfunction

    function automatic phase_e next_phase(input phase_e ph);
        case (ph)
            PH_GAP_A:    return PH_PUSH_SR;
            PH_PUSH_SR:  return PH_IACK;
            PH_IACK:     return PH_GAP_B;
            PH_GAP_B:    return PH_PUSH_PCL;
            PH_PUSH_PCL: return PH_PUSH_PCH;
            PH_PUSH_PCH: return PH_VEC_HI;
            PH_VEC_HI:   return PH_VEC_LO;
            PH_VEC_LO:   return PH_FETCH_A;
            PH_FETCH_A:  return PH_GAP_C;
            PH_GAP_C:    return PH_FETCH_B;
            default:     return PH_IDLE;
        endcase
    endfunction

    function automatic logic [15:0] entry_sr(input logic [15:0] sr, input logic [2:0] lvl);
        logic [15:0] r;
        r = sr & 16'h58FF;
        r[13] = 1'b1;
        r[10:8] = lvl;
        return r;
    endfunction

endpackage

// File: rtl/irq_seq_timer.sv
module irq_seq_timer
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   term,
    output phase_e phase,
    output logic   strobe,
    output logic   xfer,
    output logic   busy,
    output logic   done
);
    localparam int CW = 3;

    logic [CW-1:0] cnt;
    logic          at_sample;
    logic          last;

    assign at_sample = is_bus(phase) && (cnt == CW'(2));
    assign xfer      = at_sample && term;
    assign last      = (cnt == phase_len(phase) - CW'(1));
    assign strobe    = is_bus(phase) && ((cnt == CW'(1)) || (cnt == CW'(2)));
    assign busy      = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase <= PH_GAP_A;
                    cnt   <= '0;
                end
            end else if (at_sample && !term) begin
                cnt <= cnt;
            end else if (last) begin
                phase <= next_phase(phase);
                cnt   <= '0;
                if (next_phase(phase) == PH_IDLE) done <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        strobe |-> busy); // R2
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (strobe && cnt == CW'(2) && !term) |=> (strobe && $stable(phase))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
    import irq_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  phase_e        phase,
    input  logic          strobe,
    input  logic [2:0]    level,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] pc,
    input  logic [15:0]   sr_old,
    input  logic [7:0]    vec_num,
    input  logic [AW-1:0] handler,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [2:0]    fc,
    output logic [DW-1:0] wdata
);
    localparam int HI_W = AW - 16;

    logic [AW-1:0] vec_base;
    logic [AW-1:0] iack_addr;

    assign vec_base  = {{(AW-10){1'b0}}, vec_num, 2'b00};
    assign iack_addr = {{(AW-4){1'b1}}, level, 1'b0};

    always_comb begin
        addr  = '0;
        rw    = 1'b1;
        fc    = 3'b000;
        wdata = '0;
        case (phase)
            PH_PUSH_SR: begin
                addr = sp - AW'(6); rw = 1'b0; fc = FC_SDATA; wdata = DW'(sr_old);
            end
            PH_IACK: begin
                addr = iack_addr; fc = FC_CPU;
            end
            PH_PUSH_PCL: begin
                addr = sp - AW'(2); rw = 1'b0; fc = FC_SDATA; wdata = pc[15:0];
            end
            PH_PUSH_PCH: begin
                addr = sp - AW'(4); rw = 1'b0; fc = FC_SDATA;
                wdata = {{(DW-HI_W){1'b0}}, pc[AW-1:16]};
            end
            PH_VEC_HI:  begin addr = vec_base;            fc = FC_SDATA; end
            PH_VEC_LO:  begin addr = vec_base + AW'(2);   fc = FC_SDATA; end
            PH_FETCH_A: begin addr = handler;             fc = FC_SPROG; end
            PH_FETCH_B: begin addr = handler + AW'(2);    fc = FC_SPROG; end
            default: ;
        endcase
    end

    AST_WRITE_SDATA: assert property (@(posedge strobe)
        !rw |-> (fc == FC_SDATA)); // R4

endmodule

// File: rtl/irq_seq_vector.sv
module irq_seq_vector
    import irq_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic          xfer,
    input  logic [2:0]    level,
    input  logic          dtack,
    input  logic          vpa,
    input  logic          berr,
    input  logic [DW-1:0] rdata,
    output logic [7:0]    vec_num,
    output logic [AW-1:0] handler
);
    localparam int HI_W = AW - 16;

    typedef enum logic [1:0] {SRC_DATA, SRC_AUTO, SRC_SPUR} ack_src_e;

    ack_src_e src;
    always_comb begin
        if (berr)      src = SRC_SPUR;
        else if (vpa)  src = SRC_AUTO;
        else           src = SRC_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_num <= '0;
            handler <= '0;
        end else if (xfer) begin
            case (phase)
                PH_IACK: begin
                    case (src)
                        SRC_SPUR: vec_num <= VEC_SPURIOUS;
                        SRC_AUTO: vec_num <= VEC_AUTO_BASE + {5'd0, level};
                        default:  vec_num <= rdata[7:0];
                    endcase
                end
                PH_VEC_HI: handler[AW-1:16] <= rdata[HI_W-1:0];
                PH_VEC_LO: handler[15:0]    <= rdata[15:0];
                default: ;
            endcase
        end
    end

    AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (rst)
        (xfer && phase == PH_IACK && berr) |=> (vec_num == VEC_SPURIOUS)); // R8
    AST_AUTO_VEC: assert property (@(posedge clk) disable iff (rst)
        (xfer && phase == PH_IACK && vpa && !berr) |=> (vec_num[7:3] == 5'd3)); // R7

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take_req,
    input  logic [2:0]    irq_level,
    input  logic [15:0]   cur_sr,
    input  logic [AW-1:0] cur_sp,
    input  logic [AW-1:0] cur_pc,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rw,
    output logic          bus_as,
    output logic [2:0]    bus_fc,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_dtack,
    input  logic          bus_vpa,
    input  logic          bus_vpa_sync,
    input  logic          bus_berr,
    output logic          busy,
    output logic          done,
    output logic [15:0]   sv_sr,
    output logic [AW-1:0] sv_sp,
    output logic [AW-1:0] sv_pc
);
    phase_e        phase;
    logic          xfer;
    logic          term;
    logic          accept;
    logic [2:0]    lvl_q;
    logic [15:0]   sr_q;
    logic [AW-1:0] sp_q;
    logic [AW-1:0] pc_q;
    logic [7:0]    vec_num;

    assign accept = take_req && !busy;
    assign term   = (phase == PH_IACK)
                  ? (bus_berr || bus_dtack || (bus_vpa && bus_vpa_sync))
                  : bus_dtack;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            sr_q  <= '0;
            sp_q  <= '0;
            pc_q  <= '0;
        end else if (accept) begin
            lvl_q <= irq_level;
            sr_q  <= cur_sr;
            sp_q  <= cur_sp;
            pc_q  <= cur_pc;
        end
    end

    irq_seq_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .term   (term),
        .phase  (phase),
        .strobe (bus_as),
        .xfer   (xfer),
        .busy   (busy),
        .done   (done)
    );

    irq_seq_vector #(.AW(AW), .DW(DW)) u_vector (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .xfer    (xfer),
        .level   (lvl_q),
        .dtack   (bus_dtack),
        .vpa     (bus_vpa),
        .berr    (bus_berr),
        .rdata   (bus_rdata),
        .vec_num (vec_num),
        .handler (sv_pc)
    );

    irq_seq_bus #(.AW(AW), .DW(DW)) u_bus (
        .phase   (phase),
        .strobe  (bus_as),
        .level   (lvl_q),
        .sp      (sp_q),
        .pc      (pc_q),
        .sr_old  (sr_q),
        .vec_num (vec_num),
        .handler (sv_pc),
        .addr    (bus_addr),
        .rw      (bus_rw),
        .fc      (bus_fc),
        .wdata   (bus_wdata)
    );

    assign sv_sr = entry_sr(sr_q, lvl_q);
    assign sv_sp = sp_q - AW'(6);

    AST_IACK_SPACE: assert property (@(posedge clk) disable iff (rst)
        (bus_as && bus_fc == FC_CPU) |-> (bus_rw && (&bus_addr[AW-1:4]) && bus_addr[3:1] == lvl_q)); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_as && $past(bus_as)) |-> $stable(bus_addr)); // R2
    AST_SUPER_MODE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sv_sr[13] && !sv_sr[15])); // R10
    AST_INPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sp_q)); // R11

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        take_req = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [15:0] cur_sr = '0;
    logic [23:0] cur_sp = '0;
    logic [23:0] cur_pc = '0;
    logic [23:0] bus_addr;
    logic        bus_rw, bus_as;
    logic [2:0]  bus_fc;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_dtack = 1'b0, bus_vpa = 1'b0, bus_vpa_sync = 1'b0, bus_berr = 1'b0;
    logic        busy, done;
    logic [15:0] sv_sr;
    logic [23:0] sv_sp, sv_pc;

    always #10 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (.*);

    int nchk = 0, nfail = 0;
    int mode = 0, wt = 0, stalls = 0, busy_cnt = 0, age = 0, ecnt = 0;
    bit in_cyc = 0, iack_cyc = 0;
    logic [7:0] ackdat = '0;
    logic [43:0] expq[$];
    string tagq[$];

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    // Bus responder and reference comparison
    always @(negedge clk) begin
        ecnt = (ecnt == 6) ? 0 : ecnt + 1;
        bus_vpa_sync = (ecnt == 0);
        if (busy) busy_cnt++;
        if (bus_as) begin
            logic ready, tm;
            if (!in_cyc) begin
                logic [43:0] e;
                string t;
                in_cyc = 1; age = 0;
                iack_cyc = (bus_fc == 3'b111);
                if (expq.size() == 0) begin
                    chk(0, "R2 unexpected bus cycle", {24'd0, bus_addr}, 48'd0);
                end else begin
                    e = expq.pop_front(); t = tagq.pop_front();
                    chk(bus_addr == e[43:20], {t, " addr"}, bus_addr, e[43:20]);
                    chk(bus_rw == e[19] && bus_fc == e[18:16], {t, " rw/fc"}, {bus_rw, bus_fc}, {e[19], e[18:16]});
                    if (!e[19]) chk(bus_wdata == e[15:0], {t, " wdata"}, bus_wdata, e[15:0]);
                end
            end else age++;
            ready = (age >= 1 + wt);
            bus_dtack = 0; bus_vpa = 0; bus_berr = 0;
            if (iack_cyc) begin
                bus_rdata = {8'hEE, ackdat};
                case (mode)
                    0: bus_dtack = ready;
                    1: bus_vpa = ready;
                    2: bus_berr = ready;
                    default: begin bus_dtack = ready; bus_berr = ready; end
                endcase
                tm = bus_dtack | bus_berr | (bus_vpa & bus_vpa_sync);
            end else begin
                bus_rdata = rd(bus_addr);
                bus_dtack = ready;
                tm = bus_dtack;
            end
            if (age >= 1 && !tm) stalls++;
        end else begin
            in_cyc = 0; bus_dtack = 0; bus_vpa = 0; bus_berr = 0;
        end
    end

    task automatic run(input logic [2:0] lvl, input logic [15:0] sr, input logic [23:0] sp,
                       input logic [23:0] pc, input int m, input int w, input logic [7:0] ad,
                       input bit bump, input string vtag);
        logic [7:0]  vec;
        logic [23:0] va, hpc;
        logic [15:0] esr;
        vec = (m == 0) ? ad : (m == 1) ? 8'd24 + {5'd0, lvl} : 8'd24;
        va  = {14'd0, vec, 2'b00};
        hpc = {rd(va)[7:0], rd(va + 24'd2)};
        esr = (sr & 16'h58FF) | 16'h2000 | {5'd0, lvl, 8'd0};
        expq.push_back({sp - 24'd6, 1'b0, 3'b101, sr});                 tagq.push_back("R4 push sr");
        expq.push_back({16'hFFFF, 4'hF, lvl, 1'b0, 1'b1, 3'b111, 16'h0}); tagq.push_back("R5 iack");
        expq.push_back({sp - 24'd2, 1'b0, 3'b101, pc[15:0]});           tagq.push_back("R4 push pc low");
        expq.push_back({sp - 24'd4, 1'b0, 3'b101, 8'h00, pc[23:16]});   tagq.push_back("R4 push pc high");
        expq.push_back({va, 1'b1, 3'b101, 16'h0});                      tagq.push_back("R9 vector hi");
        expq.push_back({va + 24'd2, 1'b1, 3'b101, 16'h0});              tagq.push_back("R9 vector lo");
        expq.push_back({hpc, 1'b1, 3'b110, 16'h0});                     tagq.push_back("R9 fetch a");
        expq.push_back({hpc + 24'd2, 1'b1, 3'b110, 16'h0});             tagq.push_back("R9 fetch b");
        mode = m; wt = w; ackdat = ad; stalls = 0; busy_cnt = 0;
        irq_level = lvl; cur_sr = sr; cur_sp = sp; cur_pc = pc; take_req = 1;
        @(negedge clk);
        take_req = 0;
        if (bump) begin
            repeat (10) @(negedge clk);
            irq_level = ~lvl; cur_sr = ~sr; cur_sp = sp + 24'h100; cur_pc = ~pc; take_req = 1;
            @(negedge clk);
            take_req = 0;
        end
        while (busy) @(negedge clk);
        chk(busy_cnt == 44 + stalls, (w == 0 && stalls == 0) ? "R2 schedule length" : "R3 stretched length",
            busy_cnt, 44 + stalls);
        chk(done == 1'b1, "R11 done after busy", done, 1);
        chk(sv_pc == hpc, vtag, sv_pc, hpc);
        chk(sv_sr == esr, "R10 new sr", sv_sr, esr);
        chk(sv_sp == sp - 24'd6, "R4 new sp", sv_sp, sp - 24'd6);
        chk(expq.size() == 0, "R2 all bus cycles seen", expq.size(), 0);
        expq.delete(); tagq.delete();
        @(negedge clk);
        chk(done == 1'b0, "R11 done single clock", done, 0);
        chk(bus_as == 1'b0 && busy == 1'b0, "R11 idle after", {busy, bus_as}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R2 actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && bus_as == 0 && done == 0, "R1 reset state", {busy, bus_as, done}, 0);
        run(3'd5, 16'h0700, 24'h00FF00, 24'h123456, 0, 0, 8'h40, 0, "R6 data vector");
        run(3'd2, 16'h8015, 24'h010000, 24'hABCDEF, 0, 2, 8'h41, 0, "R6 data vector waits");
        run(3'd6, 16'hFFFF, 24'h002000, 24'h000102, 1, 0, 8'h99, 0, "R7 autovector");
        run(3'd1, 16'h2300, 24'h003000, 24'hFEDCBA, 1, 3, 8'h99, 0, "R7 autovector late");
        run(3'd7, 16'h0000, 24'h004000, 24'h5A5A5A, 2, 1, 8'h42, 0, "R8 spurious");
        run(3'd4, 16'h1234, 24'h005000, 24'h777777, 3, 0, 8'h43, 0, "R8 berr beats dtack");
        run(3'd3, 16'h4321, 24'h006000, 24'h010203, 0, 0, 8'h44, 1, "R11 busy ignores request");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule